// File: doc/BRIEF.md
# Programmable-Logic Configuration Store with Readback Lock

This block keeps every configuration bit of a small programmable logic device: the fuse rows of the AND array, a mode bit and a polarity bit for each of the output cells, and a 64-bit user signature. Bits are loaded one at a time through an addressed write port during a programming session. A one-cycle read port returns any stored bit so that a programmer can verify it. The array sees its fuses through a row-select port, and the cells see their bit pairs on a flat vector. Both show only the contents of the last completed session.

A programming session always starts with an automatic erase. Every bit in the session's working copy, including the lock bit, is set to zero before the first write is accepted. Storage is double-banked. A session fills the bank not in use, and the end of the session makes that bank the active one. Once a session has committed with the lock bit set, readback of array and cell bits is refused. Signature bits stay readable in every lock state. The only way to clear the lock is a new session, which erases everything.

The sequencer has three states. IDLE goes to ERASE on `prog_start`. ERASE lasts one cycle, wipes the working bank and always goes to LOAD. LOAD goes back to IDLE on `prog_done`, which is the commit. A `prog_start` seen while the sequencer is in ERASE or LOAD is ignored.

Top module: `pld_cfg_store`

## Requirements
- R1: After reset, `cell_cfg` is zero, every array row reads zero, and every readback returns 0 with `rd_denied` low, including the lock address 6432.
- R2: Fuse address a (0..6343) maps to row a/52, column a%52. After a commit, the row-select port shows that row with bit column equal to the stored fuse, and readback of a returns the stored bit.
- R3: Address 6344+2k holds the mode bit of cell k and appears on `cell_cfg[2k]`. Address 6345+2k holds its polarity bit and appears on `cell_cfg[2k+1]`. Cells are numbered k = 0..11.
- R4: Address 6368+i holds signature bit i, so byte j is bits 8j..8j+7 and byte 0 is the least significant byte. Signature readback returns the stored bit whatever the lock state.
- R5: Writing 1 to address 6432 sets the lock bit. Writing 0 to it does not clear it. Once a session commits with the lock set, a read of any address below 6368 returns 0 with `rd_denied` = 1. The array and cell outputs are not affected by the lock.
- R6: Every session erases all fuse, cell, signature and lock bits to 0. A session that commits with no writes leaves every bit reading 0 and the lock cleared.
- R7: `prog_start` in IDLE gives exactly one ERASE cycle followed by LOAD. A write presented while the sequencer is not in LOAD is dropped, and `wr_err` is 1 on the following cycle. A `prog_start` seen during LOAD is ignored.
- R8: A write to an address above 6432 stores nothing and sets `wr_err` on the following cycle.
- R9: `arr_row_bits`, `cell_cfg` and readback reflect only the last committed session. They do not change during LOAD. They take the new contents on the cycle after `prog_done`.
- R10: A read presented with `rd_en` returns `rd_valid`, `rd_bit` and `rd_denied` on the following cycle. A read of an address above 6432 returns 0 with `rd_denied` low. A read of 6432 returns the committed lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_start | input | 1 | Start a programming session (erase, then load) |
| prog_done | input | 1 | End the session and commit the working bank |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 13 | Bit address to write |
| wr_bit | input | 1 | Value to write |
| wr_err | output | 1 | Previous write was dropped |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 13 | Bit address to read |
| rd_valid | output | 1 | Read result present |
| rd_bit | output | 1 | Read result |
| rd_denied | output | 1 | Read refused by lock |
| arr_row_sel | input | 7 | Array row to show |
| arr_row_bits | output | 52 | Committed fuses of the selected row |
| cell_cfg | output | 24 | Committed mode/polarity pairs, cell k at bits 2k+1:2k |

## Verification
The bench writes every address with an arithmetic pattern and reads the whole map back. It also compares every array row against the same pattern. This exposes a row/column mix-up, a wrong region boundary at 6343/6344 or 6367/6368, or a reversed signature byte order, because each of these shows up as pattern mismatches.

Several narrower checks follow:
- Outputs are checked before the commit, so a design that writes straight into the active bank shows its new bits early.
- A write is issued during the ERASE cycle. A design that accepts it leaves that bit set, where the erase should have cleared it.
- The lock bit is written 1 and then 0. A design that lets the 0 clear the lock lets protected bits read back.
- A full locked sweep confirms that no protected bit leaks while the signature still returns its data.
- An empty session is committed last. A design whose lock survives the erase still refuses reads after it.

// File: rtl/pld_cfg_pkg.sv
package pld_cfg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ERASE = 2'd1,
        ST_LOAD  = 2'd2
    } prog_state_t;

endpackage

// File: rtl/pld_cfg_seq.sv
module pld_cfg_seq
    import pld_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prog_start,
    input  logic prog_done,
    output logic erase,
    output logic load_ok,
    output logic commit,
    output logic act_bank
);

    prog_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            act_bank <= 1'b0;
        end else begin
            state_q <= state_d;
            if (commit) act_bank <= ~act_bank;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (prog_start) state_d = ST_ERASE;
            ST_ERASE: state_d = ST_LOAD;
            ST_LOAD:  if (prog_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        erase   = 1'b0;
        load_ok = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ERASE: erase = 1'b1;
            ST_LOAD: begin
                load_ok = 1'b1;
                commit  = prog_done;
            end
            default: ;
        endcase
    end

    // R7: one erase cycle, then load
    a_r7_erase_then_load: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> load_ok);

    // R9: active bank moves only on a commit
    a_r9_bank_held: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act_bank));

    a_r9_bank_flips: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (act_bank != $past(act_bank)));

endmodule

// File: rtl/pld_cfg_fuse_mem.sv
module pld_cfg_fuse_mem #(
    parameter int ROWS     = 122,
    parameter int ROW_BITS = 52,
    localparam int ROW_W   = $clog2(ROWS),
    localparam int COL_W   = $clog2(ROW_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                erase,
    input  logic                act_bank,
    input  logic                we,
    input  logic [ROW_W-1:0]    w_row,
    input  logic [COL_W-1:0]    w_col,
    input  logic                w_bit,
    input  logic [ROW_W-1:0]    a_row,
    output logic [ROW_BITS-1:0] a_bits,
    input  logic [ROW_W-1:0]    r_row,
    input  logic [COL_W-1:0]    r_col,
    output logic                r_bit
);

    localparam logic [ROW_W:0] ROWS_L = ROWS;

    logic [ROW_BITS-1:0] mem  [2][ROWS];
    logic [ROWS-1:0]     ok_q [2];
    logic                pend;

    assign pend = ~act_bank;

    // Row-valid flags stand in for a bulk clear of the working bank.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q[0] <= '0;
            ok_q[1] <= '0;
        end else if (erase) begin
            ok_q[pend] <= '0;
        end else if (we) begin
            ok_q[pend][w_row] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            if (ok_q[pend][w_row])
                mem[pend][w_row][w_col] <= w_bit;
            else
                mem[pend][w_row] <= {{(ROW_BITS-1){1'b0}}, w_bit} << w_col;
        end
    end

    always_comb begin
        a_bits = '0;
        if (({1'b0, a_row} < ROWS_L) && ok_q[act_bank][a_row])
            a_bits = mem[act_bank][a_row];
        r_bit = 1'b0;
        if (({1'b0, r_row} < ROWS_L) && ok_q[act_bank][r_row])
            r_bit = mem[act_bank][r_row][r_col];
    end

    // R6: erase leaves no row of the working bank valid
    a_r6_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (ok_q[$past(pend)] == '0));

endmodule

// File: rtl/pld_cfg_store.sv
module pld_cfg_store #(
    parameter int ROWS      = 122,
    parameter int ROW_BITS  = 52,
    parameter int CELLS     = 12,
    parameter int SIG_BITS  = 64,
    localparam int FUSE_N   = ROWS * ROW_BITS,
    localparam int CFG_N    = 2 * CELLS,
    localparam int SIG_BASE = FUSE_N + CFG_N,
    localparam int LOCK_A   = SIG_BASE + SIG_BITS,
    localparam int ADDR_W   = $clog2(LOCK_A + 1),
    localparam int ROW_W    = $clog2(ROWS),
    localparam int COL_W    = $clog2(ROW_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prog_start,
    input  logic                prog_done,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic                wr_bit,
    output logic                wr_err,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic                rd_valid,
    output logic                rd_bit,
    output logic                rd_denied,
    input  logic [ROW_W-1:0]    arr_row_sel,
    output logic [ROW_BITS-1:0] arr_row_bits,
    output logic [CFG_N-1:0]    cell_cfg
);

    localparam int CFG_W = $clog2(CFG_N);
    localparam int SIG_W = $clog2(SIG_BITS);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(FUSE_N);
    localparam logic [ADDR_W-1:0] A_SIG  = ADDR_W'(SIG_BASE);
    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(LOCK_A);
    localparam logic [ADDR_W-1:0] A_RB   = ADDR_W'(ROW_BITS);

    logic erase, load_ok, commit, act_bank, pend;
    logic [CFG_N-1:0]    cfg_q  [2];
    logic [SIG_BITS-1:0] sig_q  [2];
    logic                lock_q [2];

    assign pend = ~act_bank;

    pld_cfg_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_start (prog_start),
        .prog_done  (prog_done),
        .erase      (erase),
        .load_ok    (load_ok),
        .commit     (commit),
        .act_bank   (act_bank)
    );

    // Write decode
    logic w_fuse, w_cfg, w_sig, w_lock, w_oor, fm_we;
    logic [ROW_W-1:0] w_row, r_row;
    logic [COL_W-1:0] w_col, r_col;
    logic [CFG_W-1:0] w_cidx, r_cidx;
    logic [SIG_W-1:0] w_sidx, r_sidx;

    always_comb begin
        w_fuse = wr_addr < A_CFG;
        w_cfg  = !w_fuse && (wr_addr < A_SIG);
        w_sig  = (wr_addr >= A_SIG) && (wr_addr < A_LOCK);
        w_lock = wr_addr == A_LOCK;
        w_oor  = wr_addr > A_LOCK;
        w_row  = ROW_W'(wr_addr / A_RB);
        w_col  = COL_W'(wr_addr % A_RB);
        w_cidx = CFG_W'(wr_addr - A_CFG);
        w_sidx = SIG_W'(wr_addr - A_SIG);
        fm_we  = wr_en && load_ok && w_fuse;
    end

    // Read decode
    logic r_fuse, r_cfg, r_sig, r_lock, r_prot, r_val, fm_rbit;

    always_comb begin
        r_fuse = rd_addr < A_CFG;
        r_cfg  = !r_fuse && (rd_addr < A_SIG);
        r_sig  = (rd_addr >= A_SIG) && (rd_addr < A_LOCK);
        r_lock = rd_addr == A_LOCK;
        r_row  = ROW_W'(rd_addr / A_RB);
        r_col  = COL_W'(rd_addr % A_RB);
        r_cidx = CFG_W'(rd_addr - A_CFG);
        r_sidx = SIG_W'(rd_addr - A_SIG);
        r_val  = 1'b0;
        if (r_fuse)      r_val = fm_rbit;
        else if (r_cfg)  r_val = cfg_q[act_bank][r_cidx];
        else if (r_sig)  r_val = sig_q[act_bank][r_sidx];
        else if (r_lock) r_val = lock_q[act_bank];
        r_prot = (r_fuse || r_cfg) && lock_q[act_bank];
    end

    pld_cfg_fuse_mem #(
        .ROWS     (ROWS),
        .ROW_BITS (ROW_BITS)
    ) u_fuse (
        .clk      (clk),
        .rst_n    (rst_n),
        .erase    (erase),
        .act_bank (act_bank),
        .we       (fm_we),
        .w_row    (w_row),
        .w_col    (w_col),
        .w_bit    (wr_bit),
        .a_row    (arr_row_sel),
        .a_bits   (arr_row_bits),
        .r_row    (r_row),
        .r_col    (r_col),
        .r_bit    (fm_rbit)
    );

    // Small banked registers: cells, signature, lock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                cfg_q[b]  <= '0;
                sig_q[b]  <= '0;
                lock_q[b] <= 1'b0;
            end
            wr_err <= 1'b0;
        end else begin
            wr_err <= wr_en && (!load_ok || w_oor);
            if (erase) begin
                cfg_q[pend]  <= '0;
                sig_q[pend]  <= '0;
                lock_q[pend] <= 1'b0;
            end else if (wr_en && load_ok) begin
                if (w_cfg) cfg_q[pend][w_cidx] <= wr_bit;
                if (w_sig) sig_q[pend][w_sidx] <= wr_bit;
                if (w_lock && wr_bit) lock_q[pend] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_bit    <= 1'b0;
            rd_denied <= 1'b0;
        end else begin
            rd_valid  <= rd_en;
            rd_bit    <= rd_en && r_val && !r_prot;
            rd_denied <= rd_en && r_prot;
        end
    end

    assign cell_cfg = cfg_q[act_bank];

    // R5: a refused read never carries data
    a_r5_denied_is_blank: assert property (@(posedge clk) disable iff (!rst_n)
        rd_denied |-> !rd_bit);

    // R10: read answers on the next cycle
    a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R7: writes outside the load window are flagged
    a_r7_write_outside_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !load_ok) |=> wr_err);

    // R8: out-of-range write flagged
    a_r8_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr > A_LOCK)) |=> wr_err);

    // R9: cell outputs move only after a commit
    a_r9_cells_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cell_cfg));

endmodule

// File: tb/pld_cfg_store_bench.sv
module pld_cfg_store_bench;

    localparam int ROWS = 122, RB = 52, NCELL = 12, SIGN = 64;
    localparam int FUSE_N = ROWS * RB;
    localparam int SIG_A = FUSE_N + 2 * NCELL;
    localparam int LOCK_A = SIG_A + SIGN;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        prog_start = 1'b0, prog_done = 1'b0;
    logic        wr_en = 1'b0, wr_bit = 1'b0, rd_en = 1'b0;
    logic [12:0] wr_addr = '0, rd_addr = '0;
    logic [6:0]  arr_row_sel = '0;
    logic        wr_err, rd_valid, rd_bit, rd_denied;
    logic [51:0] arr_row_bits;
    logic [23:0] cell_cfg;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    pld_cfg_store u_pld_cfg_store (
        .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .prog_done(prog_done),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit), .wr_err(wr_err),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_bit(rd_bit),
        .rd_denied(rd_denied), .arr_row_sel(arr_row_sel),
        .arr_row_bits(arr_row_bits), .cell_cfg(cell_cfg)
    );

    function automatic logic pat(int a);
        return ((a * 37 + (a >> 4)) % 5) < 2;
    endfunction

    function automatic logic [51:0] pat_row(int r);
        logic [51:0] v;
        for (int c = 0; c < RB; c++) v[c] = pat(r * RB + c);
        return v;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] got,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input logic d);
        wr_en = 1'b1; wr_addr = 13'(a); wr_bit = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic d, output logic den);
        rd_en = 1'b1; rd_addr = 13'(a);
        tick();
        rd_en = 1'b0;
        d = rd_bit; den = rd_denied;
        chk(rd_valid == 1'b1, "R10 rd_valid", 64'(rd_valid), 64'd1);
    endtask

    task automatic pulse_start();
        prog_start = 1'b1; tick(); prog_start = 1'b0;
    endtask

    task automatic pulse_done();
        prog_done = 1'b1; tick(); prog_done = 1'b0;
    endtask

    task automatic row_at(input int r, output logic [51:0] v);
        arr_row_sel = 7'(r);
        #1;
        v = arr_row_bits;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic d, den;
        logic [51:0] rv;
        logic [23:0] cexp;

        #10; rst_n = 1'b1; tick();

        // R1: reset state
        chk(cell_cfg == '0, "R1 cell_cfg", 64'(cell_cfg), 0);
        row_at(0, rv);
        chk(rv == '0, "R1 row0", 64'(rv), 0);
        rd(0, d, den);
        chk(!d && !den, "R1 read addr0", {d, den}, 0);
        rd(LOCK_A, d, den);
        chk(!d && !den, "R1 lock read", {d, den}, 0);

        // Session 1: full-map pattern
        pulse_start(); tick();
        for (int a = 0; a < LOCK_A; a++) wr(a, pat(a));
        wr(LOCK_A, 1'b0);
        wr(LOCK_A + 40, 1'b1);
        chk(wr_err == 1'b1, "R8 out-of-range write flag", 64'(wr_err), 1);
        // R9: nothing visible before commit
        chk(cell_cfg == '0, "R9 cells before commit", 64'(cell_cfg), 0);
        row_at(3, rv);
        chk(rv == '0, "R9 row before commit", 64'(rv), 0);
        rd(5, d, den);
        chk(d == 1'b0, "R9 readback before commit", 64'(d), 0);
        pulse_done();

        for (int k = 0; k < 2 * NCELL; k++) cexp[k] = pat(FUSE_N + k);
        chk(cell_cfg == cexp, "R3 cell_cfg after commit", 64'(cell_cfg), 64'(cexp));
        for (int r = 0; r < ROWS; r++) begin
            row_at(r, rv);
            chk(rv == pat_row(r), "R2 array row", 64'(rv), 64'(pat_row(r)));
        end
        for (int a = 0; a < LOCK_A; a++) begin
            rd(a, d, den);
            chk(d == pat(a) && !den, a < FUSE_N ? "R2 fuse readback" :
                (a < SIG_A ? "R3 cell readback" : "R4 signature readback"),
                {d, den}, {pat(a), 1'b0});
        end
        rd(LOCK_A, d, den);
        chk(!d && !den, "R10 lock readback unlocked", {d, den}, 0);
        rd(LOCK_A + 300, d, den);
        chk(!d && !den, "R10 out-of-range read", {d, den}, 0);

        // R7: write while idle is dropped
        wr(200, ~pat(200));
        chk(wr_err == 1'b1, "R7 idle write flag", 64'(wr_err), 1);
        rd(200, d, den);
        chk(d == pat(200), "R7 idle write ignored", 64'(d), 64'(pat(200)));

        // Session 2: sparse writes and lock
        pulse_start();
        wr(1, 1'b1);
        chk(wr_err == 1'b1, "R7 write during erase flag", 64'(wr_err), 1);
        wr(100, 1'b1);
        wr(FUSE_N - 1, 1'b1);
        wr(FUSE_N, 1'b1);
        wr(SIG_A - 1, 1'b1);
        wr(SIG_A, 1'b1);
        wr(LOCK_A - 1, 1'b1);
        wr(LOCK_A, 1'b1);
        wr(LOCK_A, 1'b0);
        chk(wr_err == 1'b0, "R5 lock write accepted", 64'(wr_err), 0);
        pulse_start();
        chk(cell_cfg == cexp, "R9 cells held mid-session", 64'(cell_cfg), 64'(cexp));
        pulse_done();

        chk(cell_cfg == 24'h800001, "R3 cell ends", 64'(cell_cfg), 64'h800001);
        row_at(1, rv);
        chk(rv == (52'd1 << 48), "R2 row1 under lock", 64'(rv), 64'(52'd1 << 48));
        row_at(121, rv);
        chk(rv == (52'd1 << 51), "R2 last row", 64'(rv), 64'(52'd1 << 51));
        row_at(0, rv);
        chk(rv == '0, "R6 row0 erased", 64'(rv), 0);
        for (int a = 0; a < SIG_A; a++) begin
            rd(a, d, den);
            chk(!d && den, "R5 locked read refused", {d, den}, 64'd1);
        end
        for (int i = 0; i < SIGN; i++) begin
            rd(SIG_A + i, d, den);
            chk(d == (i == 0 || i == SIGN - 1) && !den, "R4 signature under lock",
                {d, den}, {(i == 0 || i == SIGN - 1), 1'b0});
        end
        rd(LOCK_A, d, den);
        chk(d && !den, "R10 lock readback set", {d, den}, 64'd2);

        // Session 3: empty session clears lock
        pulse_start(); tick();
        pulse_done();
        chk(cell_cfg == '0, "R6 cells erased", 64'(cell_cfg), 0);
        for (int a = 0; a <= LOCK_A; a++) begin
            rd(a, d, den);
            chk(!d && !den, "R6 erased and unlocked", {d, den}, 0);
        end
        row_at(1, rv);
        chk(rv == '0, "R6 row1 erased", 64'(rv), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule